// File: doc/BRIEF.md
# Host Bus Write Port with Transmit-Stream Select

This block is the write side of a slave port on an asynchronous parallel host bus with a 16-bit data bus. The host drives active-low chip-select and write strobes, a word address, the data bus and a stream-select input. The block samples all of them on a fast internal clock. It turns each completed bus write into one single-cycle pulse in that clock domain.

With the stream select low, the captured address is decoded. One fixed word address becomes a push into the transmit data FIFO. Every other address becomes a register-write pulse that carries the address and the data. With the stream select high, the address is not decoded at all and every write becomes a transmit push. A host that has to auto-increment its address on each access can then still stream into the one FIFO.

A bus write lasts exactly as long as both strobes are low together, whatever order they move in. The block commits the write on the detected end of that overlap. It uses the address, select and data from the last clock sample taken inside the overlap, so data that settles late in the cycle is the value delivered. Reads, the FIFO storage and the register storage are handled elsewhere.

Top module: `hbus_wr_port`

## Requirements
- R1: A synchronous active-high reset clears all state. During reset, and on the first cycle after it, `tx_push` and `reg_wr` are both 0.
- R2: While only one of `bus_cs_n` and `bus_we_n` is low, no `tx_push` or `reg_wr` pulse is produced.
- R3: With `bus_fsel` = 0 and `bus_addr` equal to parameter `FIFO_ADDR` (default 7'h10), a write gives one `tx_push` pulse with `tx_data` equal to the written data, and no `reg_wr`.
- R4: With `bus_fsel` = 0 and any other address, a write gives one `reg_wr` pulse with `reg_addr` and `reg_data` equal to the written address and data, and no `tx_push`.
- R5: With `bus_fsel` = 1, every write gives one `tx_push` pulse with the written data, whatever the address, and no `reg_wr`.
- R6: Exactly one pulse is produced per bus write for all four orders of strobe assertion and deassertion.
- R7: The delivered data is the value present on the data bus in the last clock sample before the strobe overlap ended. Earlier values held during the same overlap are not used.
- R8: Every output pulse lasts one clock cycle. `tx_push` and `reg_wr` are never high together, and `reg_wr` never carries `FIFO_ADDR`.
- R9: A bus write that is already in progress when reset is released produces no pulse.
- R10: Back-to-back writes separated by an idle gap of two clocks each produce their own pulse with their own data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_we_n | input | 1 | Write strobe, active low |
| bus_addr | input | AW (7) | Word address |
| bus_fsel | input | 1 | Stream select: 1 forces every write to the transmit FIFO |
| bus_data | input | DW (16) | Write data |
| reg_wr | output | 1 | One-cycle register write pulse |
| reg_addr | output | AW (7) | Address of the register write |
| reg_data | output | DW (16) | Data of the register write |
| tx_push | output | 1 | One-cycle transmit FIFO push pulse |
| tx_data | output | DW (16) | Data of the transmit push |

## Verification
Writes are made at the FIFO address, at ordinary addresses and with the stream select high at those same addresses. This separates the address decode from the select override. Each of the four strobe orderings is used, and a lone strobe is held low to show that only the overlap counts. Data is changed part-way through an overlap to show which sample is captured. Writes are also issued back to back, and with a cycle already active across reset, to check that there is exactly one pulse per bus cycle and no pulse for a partial cycle.

// File: rtl/hbus_wr_port.sv
module hbus_wr_port #(
  parameter int AW = 7,
  parameter int DW = 16,
  parameter logic [AW-1:0] FIFO_ADDR = 7'h10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cs_n,
  input  logic          bus_we_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_fsel,
  input  logic [DW-1:0] bus_data,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_data,
  output logic          tx_push,
  output logic [DW-1:0] tx_data
);
  localparam int BW = AW + DW + 1;

  logic          act_raw;
  logic          s1, s2, s3, armed;
  logic [BW-1:0] d1, d2, cap;
  logic          fire, to_fifo;
  logic [AW-1:0] cap_addr;
  logic [DW-1:0] cap_data;
  logic          cap_sel;

  assign act_raw = ~bus_cs_n & ~bus_we_n;
  assign {cap_sel, cap_addr, cap_data} = cap;
  assign fire    = armed & s3 & ~s2;
  assign to_fifo = cap_sel | (cap_addr == FIFO_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
      armed <= 1'b0;
      d1 <= '0;
      d2 <= '0;
      cap <= '0;
    end else begin
      s1 <= act_raw;
      s2 <= s1;
      s3 <= s2;
      d1 <= {bus_fsel, bus_addr, bus_data};
      d2 <= d1;
      if (!s2) armed <= 1'b1;
      if (s2) cap <= d2;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr   <= 1'b0;
      tx_push  <= 1'b0;
      reg_addr <= '0;
      reg_data <= '0;
      tx_data  <= '0;
    end else begin
      reg_wr  <= fire & ~to_fifo;
      tx_push <= fire & to_fifo;
      if (fire & ~to_fifo) begin
        reg_addr <= cap_addr;
        reg_data <= cap_data;
      end
      if (fire & to_fifo) tx_data <= cap_data;
    end
  end
endmodule

module hbus_wr_port_chk #(
  parameter int AW = 7,
  parameter logic [AW-1:0] FIFO_ADDR = 7'h10
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          tx_push
);
  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !reg_wr && !tx_push);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (rst) !(reg_wr && tx_push));
  assert_push_single_R8: assert property (@(posedge clk) disable iff (rst) tx_push |=> !tx_push);
  assert_reg_single_R8: assert property (@(posedge clk) disable iff (rst) reg_wr |=> !reg_wr);
  assert_reg_not_fifo_R4: assert property (@(posedge clk) disable iff (rst) reg_wr |-> reg_addr != FIFO_ADDR);
endmodule

bind hbus_wr_port hbus_wr_port_chk #(.AW(AW), .FIFO_ADDR(FIFO_ADDR)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .tx_push(tx_push)
);

// File: tb/hbus_wr_port_bench.sv
module hbus_wr_port_bench;
  localparam int AW = 7;
  localparam int DW = 16;
  localparam logic [AW-1:0] FA = 7'h10;

  logic clk = 0, rst = 1;
  logic cs_n = 1, we_n = 1, fsel = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic reg_wr, tx_push;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_data, tx_data;

  int checks = 0, errors = 0, cyc = 0;
  int n_push = 0, n_reg = 0;
  logic [DW-1:0] last_tx, last_rd;
  logic [AW-1:0] last_ra;

  always #5 clk = ~clk;

  hbus_wr_port #(.AW(AW), .DW(DW), .FIFO_ADDR(FA)) u_hbus_wr_port (
    .clk(clk), .rst(rst), .bus_cs_n(cs_n), .bus_we_n(we_n), .bus_addr(addr),
    .bus_fsel(fsel), .bus_data(data), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_data(reg_data), .tx_push(tx_push), .tx_data(tx_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && tx_push) begin n_push <= n_push + 1; last_tx <= tx_data; end
    if (!rst && reg_wr) begin n_reg <= n_reg + 1; last_rd <= reg_data; last_ra <= reg_addr; end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // order: bit0 = cs first on assert, bit1 = cs first on deassert
  task automatic bus_write(logic [AW-1:0] a, logic s, logic [DW-1:0] d, int order);
    @(negedge clk);
    addr = a; fsel = s; data = d;
    if (order[0]) cs_n = 0; else we_n = 0;
    @(negedge clk);
    cs_n = 0; we_n = 0;
    idle(4);
    if (order[1]) cs_n = 1; else we_n = 1;
    @(negedge clk);
    cs_n = 1; we_n = 1;
    idle(5);
  endtask

  task automatic t_reset;
    check("R1 reg_wr", reg_wr, 0);
    check("R1 tx_push", tx_push, 0);
    check("R1 tx_data", tx_data, 0);
  endtask

  task automatic t_lone_strobe;
    int p = n_push, r = n_reg;
    @(negedge clk); addr = 7'h03; cs_n = 0; idle(6); cs_n = 1; idle(4);
    we_n = 0; idle(6); we_n = 1; idle(5);
    check("R2 pushes", n_push - p, 0);
    check("R2 regs", n_reg - r, 0);
  endtask

  task automatic t_fifo_addr;
    int p = n_push, r = n_reg;
    bus_write(FA, 0, 16'hA5C3, 0);
    check("R3 push count", n_push - p, 1);
    check("R3 reg count", n_reg - r, 0);
    check("R3 data", last_tx, 16'hA5C3);
  endtask

  task automatic t_reg_addr;
    int p = n_push, r = n_reg;
    bus_write(7'h05, 0, 16'h1234, 0);
    check("R4 reg count", n_reg - r, 1);
    check("R4 push count", n_push - p, 0);
    check("R4 addr", last_ra, 7'h05);
    check("R4 data", last_rd, 16'h1234);
  endtask

  task automatic t_fsel;
    int p = n_push, r = n_reg;
    bus_write(7'h05, 1, 16'hBEEF, 0);
    check("R5 data", last_tx, 16'hBEEF);
    bus_write(7'h7F, 1, 16'h0F0F, 1);
    bus_write(FA, 1, 16'h7777, 2);
    check("R5 push count", n_push - p, 3);
    check("R5 reg count", n_reg - r, 0);
    check("R5 data last", last_tx, 16'h7777);
  endtask

  task automatic t_orders;
    for (int o = 0; o < 4; o++) begin
      int r = n_reg;
      bus_write(7'h20 + 7'(o), 0, 16'h4000 + 16'(o), o);
      check("R6 one pulse", n_reg - r, 1);
      check("R6 addr", last_ra, 7'h20 + 7'(o));
    end
  endtask

  task automatic t_late_data;
    int p = n_push;
    @(negedge clk); addr = FA; fsel = 0; data = 16'h1111; cs_n = 0; we_n = 0;
    idle(3); data = 16'h2222; idle(2); data = 16'h3333;
    @(negedge clk); cs_n = 1; we_n = 1; idle(5);
    check("R7 count", n_push - p, 1);
    check("R7 late data", last_tx, 16'h3333);
  endtask

  task automatic t_back_to_back;
    int p = n_push;
    logic [DW-1:0] seen [3];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); addr = 7'h01; fsel = 1; data = 16'hC000 + 16'(i); cs_n = 0; we_n = 0;
      idle(3); cs_n = 1; we_n = 1; idle(2);
      idle(2); seen[i] = last_tx;
    end
    idle(4);
    check("R10 count", n_push - p, 3);
    check("R10 data0", seen[0], 16'hC000);
    check("R10 data2", last_tx, 16'hC002);
  endtask

  task automatic t_reset_mid;
    int p = n_push, r = n_reg;
    @(negedge clk); addr = 7'h09; fsel = 0; data = 16'hDEAD; cs_n = 0; we_n = 0;
    idle(2); rst = 1; idle(3); rst = 0; idle(3);
    cs_n = 1; we_n = 1; idle(6);
    check("R9 reg count", n_reg - r, 0);
    check("R9 push count", n_push - p, 0);
    bus_write(7'h09, 0, 16'hBEAD, 3);
    check("R9 recovers", n_reg - r, 1);
  endtask

  initial begin
    idle(4);
    t_reset();
    rst = 0;
    idle(3);
    t_reset();
    t_lone_strobe();
    t_fifo_addr();
    t_reg_addr();
    t_fsel();
    t_orders();
    t_late_data();
    t_back_to_back();
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=<20000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule